// File: doc/BRIEF.md
# Per-Port Power-Sourcing Mode Sequencer

This block controls one power-sourcing Ethernet port. A 2-bit mode field picks one of four operating styles: fully automatic, semi-automatic, manual and shutdown. In each of them the block runs the detection, classification and power-on phases in the order that style requires. The analog measurement front end is outside the block. The block talks to it through start pulses and done pulses, and the front end returns a detection result code or a class code. The block drives a single power-enable output and pulses a phase-end flag whenever a detection or a classification finishes.

Software controls the port through two enable bits, a power-on pulse and a power-off pulse. What the enable bits mean depends on the applied mode. In automatic and semi-automatic mode they are standing configuration. In manual mode they are one-shot pushbuttons that clear themselves. The power-on pulse overrides any phase that is running. A midspan strap adds a back-off after each failed detection. The back-off is measured in pulses of an external prescaled tick.

Top module: `pse_port_seq`

## Requirements
- R1: The mode field is encoded as 11 automatic, 10 semi-automatic, 01 manual and 00 shutdown, and `mode_o` shows the applied mode. After reset the applied mode is 00, power is off, both enable bits are 0, both status fields are 0 and no start pulse is issued.
- R2: Entering automatic mode sets both enable bits. One cycle after the mode is applied, a detection start is issued. A detection result of 3'b100 (valid) with classification enabled starts classification on the next cycle. The completion of that classification turns power on.
- R3: In automatic mode, any result other than 3'b100 with no midspan strap starts a new detection on the next cycle, with no power. If the detection enable is 0 and the bypass input is low, the port never powers up. If the bypass input is high, detection is skipped and the port classifies and then powers up.
- R4: Entering semi-automatic mode clears both enable bits. While detection is enabled, detection repeats indefinitely. The port is never powered without a power-on command.
- R5: In manual mode, `en_wdata_i` bit 0 requests one detection and bit 1 requests one classification. When both are requested, detection runs first. Each bit clears itself when its phase completes, and nothing repeats after that.
- R6: A power-on command in any non-shutdown mode turns power on in the next cycle and abandons any running phase. A done pulse for the abandoned phase raises no phase-end flag. In manual mode the command also clears both pushbutton bits.
- R7: While the port is powered, enable writes have no effect.
- R8: A change among automatic, semi-automatic and manual modes is not applied while a detection or classification is running. It is applied in the first cycle in which the sequencer is idle, backing off or powered. A powered port stays powered through the change.
- R9: Requesting shutdown takes effect on the next edge. Power drops, both status fields and both enable bits clear, and power-on commands and enable writes are ignored until shutdown is left.
- R10: In semi-automatic mode, a software power-off clears both enable bits. A power removal caused by a fault or disconnect leaves them set.
- R11: With the midspan strap set, a failed detection in automatic or semi-automatic mode waits for BACKOFF_TICKS tick pulses before the next detection start. The first detection is not delayed.
- R12: One cycle after a done pulse is accepted, the matching `det_end_o` or `cls_end_o` pulses high for exactly one cycle. The result code is latched into its status output at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Requested operating mode |
| midspan_i | input | 1 | Midspan strap: back off after a failed detection |
| det_bypass_i | input | 1 | Allow automatic power-up with detection disabled |
| en_wr_i | input | 1 | Write strobe for the enable bits |
| en_wdata_i | input | 2 | Enable write data: bit 0 detection, bit 1 classification |
| pwr_on_cmd_i | input | 1 | Single-cycle power-on command |
| pwr_off_cmd_i | input | 1 | Single-cycle software power-off command |
| fault_off_i | input | 1 | Single-cycle power removal caused by a fault or disconnect |
| tick_i | input | 1 | Prescaled timing tick for the back-off |
| det_start_o | output | 1 | Detection start pulse to the front end |
| det_done_i | input | 1 | Detection done pulse from the front end |
| det_result_i | input | DET_W | Detection result code |
| cls_start_o | output | 1 | Classification start pulse to the front end |
| cls_done_i | input | 1 | Classification done pulse from the front end |
| cls_code_i | input | CLS_W | Measured class code |
| pwr_en_o | output | 1 | Port power enable |
| det_end_o | output | 1 | Detection-finished pulse |
| cls_end_o | output | 1 | Classification-finished pulse |
| det_status_o | output | DET_W | Last detection result |
| cls_status_o | output | CLS_W | Last class result |
| det_en_o | output | 1 | Detection enable bit |
| cls_en_o | output | 1 | Classification enable bit |
| mode_o | output | 2 | Applied mode |

## Verification
A wrong sequencer state reaches the ports within one or two cycles. The next start pulse is missing, doubled or of the wrong kind, or `pwr_en_o` rises without a valid detection or a power-on command. Problems with enable-bit handling appear on `det_en_o` and `cls_en_o` at the edge where the phase ends or the mode is applied. A back-off counter that is off by one moves the retry start by exactly one cycle relative to the tick count. A mode change applied too early shows up as a classification start that does not follow the old mode's rules.

// File: rtl/pse_seq_pkg.sv
package pse_seq_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_MAN  = 2'b01,
    MODE_SEMI = 2'b10,
    MODE_AUTO = 2'b11
  } pse_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DET     = 3'd1,
    ST_BACKOFF = 3'd2,
    ST_CLS     = 3'd3,
    ST_PWR     = 3'd4
  } pse_state_e;

  // A requested mode is applied at once for shutdown, otherwise only
  // when no measurement phase is in flight.
  function automatic logic mode_switch_ok(pse_state_e st, pse_mode_e cur, pse_mode_e req);
    return (req != cur) &&
           ((req == MODE_OFF) || (st == ST_IDLE) || (st == ST_BACKOFF) || (st == ST_PWR));
  endfunction

  // Enable bits {cls, det} loaded on entry to a mode.
  function automatic logic [1:0] entry_enables(pse_mode_e m);
    return (m == MODE_AUTO) ? 2'b11 : 2'b00;
  endfunction

endpackage

// File: rtl/pse_backoff_timer.sv
module pse_backoff_timer #(
  parameter int unsigned TICKS = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic clear_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign expired_o = run_q && (cnt_q == CNT_W'(TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q && tick_i && !expired_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r11_no_early_expire: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !expired_o);

endmodule

// File: rtl/pse_enable_bits.sv
module pse_enable_bits
  import pse_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enter_i,
  input  pse_mode_e enter_mode_i,
  input  logic      wr_i,
  input  logic      wr_ok_i,
  input  logic [1:0] wdata_i,
  input  logic      det_clr_i,
  input  logic      cls_clr_i,
  input  logic      all_clr_i,
  output logic      det_en_o,
  output logic      cls_en_o
);
  logic [1:0] en_q;   // {cls, det}
  logic [1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (enter_i) begin
      en_d = entry_enables(enter_mode_i);
    end else if (all_clr_i) begin
      en_d = 2'b00;
    end else begin
      if (wr_i && wr_ok_i) en_d = wdata_i;
      // self-clear beats a coincident write
      if (det_clr_i) en_d[0] = 1'b0;
      if (cls_clr_i) en_d[1] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 2'b00;
    else        en_q <= en_d;
  end

  assign det_en_o = en_q[0];
  assign cls_en_o = en_q[1];

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (det_clr_i && !enter_i) |=> !det_en_o);

endmodule

// File: rtl/pse_phase_fsm.sv
module pse_phase_fsm
  import pse_seq_pkg::*;
#(
  parameter int unsigned DET_W     = 3,
  parameter int unsigned CLS_W     = 3,
  parameter int unsigned DET_VALID = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pse_mode_e        mode_i,
  input  logic             midspan_i,
  input  logic             det_bypass_i,
  input  logic             pwr_on_cmd_i,
  input  logic             pwr_off_cmd_i,
  input  logic             fault_off_i,
  input  logic             det_done_i,
  input  logic [DET_W-1:0] det_result_i,
  input  logic             cls_done_i,
  input  logic [CLS_W-1:0] cls_code_i,
  input  logic             det_en_i,
  input  logic             cls_en_i,
  input  logic             bo_expired_i,
  output pse_mode_e        mode_q_o,
  output logic             apply_o,
  output logic             wr_ok_o,
  output logic             det_clr_o,
  output logic             cls_clr_o,
  output logic             all_clr_o,
  output logic             bo_load_o,
  output logic             bo_clear_o,
  output logic             det_start_o,
  output logic             cls_start_o,
  output logic             det_end_o,
  output logic             cls_end_o,
  output logic [DET_W-1:0] det_status_o,
  output logic [CLS_W-1:0] cls_status_o,
  output logic             pwr_en_o
);
  pse_state_e       state_q, state_d;
  pse_mode_e        mode_q;
  logic             active, pwr_take, det_acc, cls_acc, det_valid, soft_off;
  logic             det_start_q, cls_start_q, det_end_q, cls_end_q;
  logic [DET_W-1:0] det_stat_q;
  logic [CLS_W-1:0] cls_stat_q;

  // named events
  assign apply_o   = mode_switch_ok(state_q, mode_q, mode_i);
  assign active    = (mode_q != MODE_OFF);
  assign pwr_take  = active && !apply_o && pwr_on_cmd_i && (state_q != ST_PWR);
  assign det_acc   = active && !apply_o && !pwr_take && (state_q == ST_DET) && det_done_i;
  assign cls_acc   = active && !apply_o && !pwr_take && (state_q == ST_CLS) && cls_done_i;
  assign det_valid = (det_result_i == DET_W'(DET_VALID));
  assign soft_off  = active && !apply_o && pwr_off_cmd_i && (mode_q == MODE_SEMI);
  assign wr_ok_o   = active && !apply_o && !pwr_take && (state_q != ST_PWR);

  always_comb begin
    state_d   = state_q;
    det_clr_o = 1'b0;
    cls_clr_o = 1'b0;
    all_clr_o = soft_off;
    if (apply_o) begin
      if (mode_i == MODE_OFF || state_q == ST_BACKOFF) state_d = ST_IDLE;
    end else if (!active) begin
      state_d = ST_IDLE;
    end else if (pwr_take) begin
      state_d = ST_PWR;
      if (mode_q == MODE_MAN) all_clr_o = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (det_en_i)                 state_d = ST_DET;
          else if (mode_q == MODE_AUTO) begin
            if (det_bypass_i)           state_d = cls_en_i ? ST_CLS : ST_PWR;
          end else if (cls_en_i)        state_d = ST_CLS;
        end
        ST_DET: if (det_done_i) begin
          if (mode_q == MODE_MAN) begin
            det_clr_o = 1'b1;
            state_d   = cls_en_i ? ST_CLS : ST_IDLE;
          end else if (det_valid) begin
            state_d = cls_en_i ? ST_CLS : ((mode_q == MODE_AUTO) ? ST_PWR : ST_IDLE);
          end else if (midspan_i) begin
            state_d = ST_BACKOFF;
          end else begin
            state_d = (det_en_i && mode_q == MODE_AUTO) ? ST_DET : ST_IDLE;
          end
        end
        ST_BACKOFF: if (bo_expired_i) state_d = ST_IDLE;
        ST_CLS: if (cls_done_i) begin
          if (mode_q == MODE_MAN) cls_clr_o = 1'b1;
          state_d = (mode_q == MODE_AUTO) ? ST_PWR : ST_IDLE;
        end
        ST_PWR: if (pwr_off_cmd_i || fault_off_i) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign bo_load_o  = (state_d == ST_BACKOFF) && (state_q != ST_BACKOFF);
  assign bo_clear_o = (state_q == ST_BACKOFF) && (state_d != ST_BACKOFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      mode_q      <= MODE_OFF;
      det_start_q <= 1'b0;
      cls_start_q <= 1'b0;
      det_end_q   <= 1'b0;
      cls_end_q   <= 1'b0;
      det_stat_q  <= '0;
      cls_stat_q  <= '0;
    end else begin
      state_q     <= state_d;
      if (apply_o) mode_q <= mode_i;
      det_start_q <= (state_d == ST_DET) && ((state_q != ST_DET) || det_acc);
      cls_start_q <= (state_d == ST_CLS) && (state_q != ST_CLS);
      det_end_q   <= det_acc;
      cls_end_q   <= cls_acc;
      if (apply_o && mode_i == MODE_OFF) begin
        det_stat_q <= '0;
        cls_stat_q <= '0;
      end else begin
        if (det_acc) det_stat_q <= det_result_i;
        if (cls_acc) cls_stat_q <= cls_code_i;
      end
    end
  end

  assign mode_q_o     = mode_q;
  assign det_start_o  = det_start_q;
  assign cls_start_o  = cls_start_q;
  assign det_end_o    = det_end_q;
  assign cls_end_o    = cls_end_q;
  assign det_status_o = det_stat_q;
  assign cls_status_o = cls_stat_q;
  assign pwr_en_o     = (state_q == ST_PWR);

  a_r9_shutdown_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_OFF) |=> (!pwr_en_o && det_status_o == '0 && cls_status_o == '0));

  a_r4_semi_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SEMI && !pwr_on_cmd_i && state_q != ST_PWR) |=> !pwr_en_o);

  a_r3_no_bypass_no_power: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_AUTO && state_q == ST_IDLE && !det_en_i && !det_bypass_i && !pwr_on_cmd_i)
      |=> !pwr_en_o);

  a_r5_pushbutton_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (det_end_o && mode_q == MODE_MAN) |-> !det_en_i);

  a_r11_backoff_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BACKOFF && !bo_expired_i) |=> (state_q != ST_DET));

  a_r12_one_end_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    det_end_o |-> !cls_end_o);

endmodule

// File: rtl/pse_port_seq.sv
module pse_port_seq
  import pse_seq_pkg::*;
#(
  parameter int unsigned DET_W         = 3,
  parameter int unsigned CLS_W         = 3,
  parameter int unsigned DET_VALID     = 4,
  parameter int unsigned BACKOFF_TICKS = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             midspan_i,
  input  logic             det_bypass_i,
  input  logic             en_wr_i,
  input  logic [1:0]       en_wdata_i,
  input  logic             pwr_on_cmd_i,
  input  logic             pwr_off_cmd_i,
  input  logic             fault_off_i,
  input  logic             tick_i,
  output logic             det_start_o,
  input  logic             det_done_i,
  input  logic [DET_W-1:0] det_result_i,
  output logic             cls_start_o,
  input  logic             cls_done_i,
  input  logic [CLS_W-1:0] cls_code_i,
  output logic             pwr_en_o,
  output logic             det_end_o,
  output logic             cls_end_o,
  output logic [DET_W-1:0] det_status_o,
  output logic [CLS_W-1:0] cls_status_o,
  output logic             det_en_o,
  output logic             cls_en_o,
  output logic [1:0]       mode_o
);
  pse_mode_e mode_req, mode_cur;
  logic apply, wr_ok, det_clr, cls_clr, all_clr, bo_load, bo_clear, bo_expired;

  assign mode_req = pse_mode_e'(mode_i);
  assign mode_o   = mode_cur;

  pse_phase_fsm #(.DET_W(DET_W), .CLS_W(CLS_W), .DET_VALID(DET_VALID)) u_fsm (
    .clk, .rst_n,
    .mode_i(mode_req), .midspan_i, .det_bypass_i,
    .pwr_on_cmd_i, .pwr_off_cmd_i, .fault_off_i,
    .det_done_i, .det_result_i, .cls_done_i, .cls_code_i,
    .det_en_i(det_en_o), .cls_en_i(cls_en_o), .bo_expired_i(bo_expired),
    .mode_q_o(mode_cur), .apply_o(apply), .wr_ok_o(wr_ok),
    .det_clr_o(det_clr), .cls_clr_o(cls_clr), .all_clr_o(all_clr),
    .bo_load_o(bo_load), .bo_clear_o(bo_clear),
    .det_start_o, .cls_start_o, .det_end_o, .cls_end_o,
    .det_status_o, .cls_status_o, .pwr_en_o
  );

  pse_enable_bits u_en (
    .clk, .rst_n,
    .enter_i(apply), .enter_mode_i(mode_req),
    .wr_i(en_wr_i), .wr_ok_i(wr_ok), .wdata_i(en_wdata_i),
    .det_clr_i(det_clr), .cls_clr_i(cls_clr), .all_clr_i(all_clr),
    .det_en_o, .cls_en_o
  );

  pse_backoff_timer #(.TICKS(BACKOFF_TICKS)) u_bo (
    .clk, .rst_n,
    .load_i(bo_load), .clear_i(bo_clear), .tick_i,
    .expired_o(bo_expired)
  );

  a_r7_powered_ignores_en: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en_o && en_wr_i && mode_i == mode_o && !pwr_off_cmd_i)
      |=> $stable({det_en_o, cls_en_o}));

endmodule

// File: tb/pse_port_seq_tb.sv
module pse_port_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BO = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode_i;
  logic midspan_i, det_bypass_i, en_wr_i, pwr_on_cmd_i, pwr_off_cmd_i, fault_off_i, tick_i;
  logic [1:0] en_wdata_i;
  logic det_done_i, cls_done_i;
  logic [2:0] det_result_i, cls_code_i;
  logic det_start_o, cls_start_o, pwr_en_o, det_end_o, cls_end_o, det_en_o, cls_en_o;
  logic [2:0] det_status_o, cls_status_o;
  logic [1:0] mode_o;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pse_port_seq #(.BACKOFF_TICKS(BO)) u_dut (
    .clk, .rst_n, .mode_i, .midspan_i, .det_bypass_i, .en_wr_i, .en_wdata_i,
    .pwr_on_cmd_i, .pwr_off_cmd_i, .fault_off_i, .tick_i,
    .det_start_o, .det_done_i, .det_result_i, .cls_start_o, .cls_done_i, .cls_code_i,
    .pwr_en_o, .det_end_o, .cls_end_o, .det_status_o, .cls_status_o,
    .det_en_o, .cls_en_o, .mode_o
  );

  // rows: {detection code, class code, expect power}
  localparam logic [6:0] VEC [5] = '{
    {3'd4, 3'd2, 1'b1}, {3'd0, 3'd0, 1'b0}, {3'd1, 3'd0, 1'b0},
    {3'd4, 3'd6, 1'b1}, {3'd7, 3'd0, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mode_i = 2'b00; midspan_i = 0; det_bypass_i = 0; en_wr_i = 0;
    en_wdata_i = 0; pwr_on_cmd_i = 0; pwr_off_cmd_i = 0; fault_off_i = 0; tick_i = 0;
    det_done_i = 0; cls_done_i = 0; det_result_i = 0; cls_code_i = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic write_en(input logic [1:0] v);
    en_wr_i = 1'b1; en_wdata_i = v;
    step();
    en_wr_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1 mode after reset", mode_o, 0);
    check("R1 power after reset", pwr_en_o, 0);
    check("R1 enables after reset", {det_en_o, cls_en_o}, 0);
    check("R1 status after reset", {det_status_o, cls_status_o}, 0);
    check("R1 no start after reset", {det_start_o, cls_start_o}, 0);

    // table of automatic-mode outcomes (R2, R3, R12)
    for (int i = 0; i < 5; i++) begin
      do_reset();
      mode_i = 2'b11;
      step();
      check("R2 auto enables set", {det_en_o, cls_en_o}, 3);
      step();
      check("R2 detection start", det_start_o, 1);
      det_done_i = 1; det_result_i = VEC[i][6:4];
      step();
      det_done_i = 0;
      check("R12 det end pulse", det_end_o, 1);
      check("R12 det status", det_status_o, VEC[i][6:4]);
      if (VEC[i][0]) begin
        check("R2 classification start", cls_start_o, 1);
        cls_done_i = 1; cls_code_i = VEC[i][3:1];
        step();
        cls_done_i = 0;
        check("R2 powered after class", pwr_en_o, 1);
        check("R12 cls status", cls_status_o, VEC[i][3:1]);
        check("R12 cls end pulse", cls_end_o, 1);
      end else begin
        check("R3 retry start", det_start_o, 1);
        check("R3 no power on invalid", pwr_en_o, 0);
        check("R3 no class on invalid", cls_start_o, 0);
      end
    end

    // manual pushbuttons (R5, R12)
    do_reset();
    mode_i = 2'b01;
    step();
    check("R5 manual applied", mode_o, 1);
    check("R5 manual entry clears", {det_en_o, cls_en_o}, 0);
    write_en(2'b11);
    check("R5 buttons latched", {det_en_o, cls_en_o}, 3);
    check("R5 no start yet", det_start_o, 0);
    step();
    check("R5 detection first", det_start_o, 1);
    check("R5 no class start with det", cls_start_o, 0);
    det_done_i = 1; det_result_i = 3'd1;
    step();
    det_done_i = 0;
    check("R5 det button cleared", det_en_o, 0);
    check("R5 cls button kept", cls_en_o, 1);
    check("R5 class follows", cls_start_o, 1);
    cls_done_i = 1; cls_code_i = 3'd3;
    step();
    cls_done_i = 0;
    check("R5 cls button cleared", cls_en_o, 0);
    check("R12 cls end manual", cls_end_o, 1);
    check("R5 manual no power", pwr_en_o, 0);
    step();
    check("R12 cls end one cycle", cls_end_o, 0);
    begin
      int starts = 0;
      for (int k = 0; k < 4; k++) begin
        starts += det_start_o + cls_start_o;
        step();
      end
      check("R5 no repeat", starts, 0);
    end

    // power-on preempts (R6, R7)
    write_en(2'b01);
    step();
    check("R6 detecting", det_start_o, 1);
    pwr_on_cmd_i = 1;
    step();
    pwr_on_cmd_i = 0;
    check("R6 immediate power", pwr_en_o, 1);
    check("R6 buttons cleared", {det_en_o, cls_en_o}, 0);
    det_done_i = 1; det_result_i = 3'd4;
    step();
    det_done_i = 0;
    check("R6 aborted done ignored", det_end_o, 0);
    write_en(2'b11);
    step();
    check("R7 powered ignores enables", {det_en_o, cls_en_o}, 0);
    check("R7 still powered", pwr_en_o, 1);
    check("R7 no start while powered", det_start_o, 0);

    // deferred mode change and shutdown (R8, R9)
    do_reset();
    mode_i = 2'b11;
    step(); step();
    mode_i = 2'b01;
    step();
    check("R8 change deferred in detection", mode_o, 3);
    det_done_i = 1; det_result_i = 3'd4;
    step();
    det_done_i = 0;
    check("R8 old mode rules kept", cls_start_o, 1);
    check("R8 still old mode", mode_o, 3);
    cls_done_i = 1; cls_code_i = 3'd5;
    step();
    cls_done_i = 0;
    check("R8 powered under old mode", pwr_en_o, 1);
    step();
    check("R8 change applied when powered", mode_o, 1);
    check("R8 power kept through change", pwr_en_o, 1);
    check("R9 status before shutdown", {det_status_o, cls_status_o}, {3'd4, 3'd5});
    mode_i = 2'b00;
    step();
    check("R9 power dropped", pwr_en_o, 0);
    check("R9 status cleared", {det_status_o, cls_status_o}, 0);
    check("R9 mode off", mode_o, 0);
    pwr_on_cmd_i = 1;
    step();
    pwr_on_cmd_i = 0;
    step();
    check("R9 power-on ignored", pwr_en_o, 0);
    write_en(2'b11);
    check("R9 enable write ignored", {det_en_o, cls_en_o}, 0);

    // semi-automatic (R4, R6, R10)
    do_reset();
    mode_i = 2'b10;
    step();
    check("R4 semi applied", mode_o, 2);
    check("R4 semi entry clears", {det_en_o, cls_en_o}, 0);
    begin
      int starts = 0;
      for (int k = 0; k < 3; k++) begin
        step();
        starts += det_start_o;
      end
      check("R4 idle until enabled", starts, 0);
    end
    write_en(2'b01);
    step();
    check("R4 detection starts", det_start_o, 1);
    det_done_i = 1; det_result_i = 3'd4;
    step();
    det_done_i = 0;
    check("R4 det end semi", det_end_o, 1);
    check("R4 valid does not power", pwr_en_o, 0);
    step();
    check("R4 detection repeats", det_start_o, 1);
    pwr_on_cmd_i = 1;
    step();
    pwr_on_cmd_i = 0;
    check("R6 semi power-on", pwr_en_o, 1);
    pwr_off_cmd_i = 1;
    step();
    pwr_off_cmd_i = 0;
    check("R10 software off drops power", pwr_en_o, 0);
    check("R10 software off clears enables", {det_en_o, cls_en_o}, 0);
    write_en(2'b01);
    step();
    pwr_on_cmd_i = 1;
    step();
    pwr_on_cmd_i = 0;
    check("R6 semi power-on again", pwr_en_o, 1);
    fault_off_i = 1;
    step();
    fault_off_i = 0;
    check("R10 fault drops power", pwr_en_o, 0);
    check("R10 fault keeps enables", det_en_o, 1);

    // automatic with detection disabled, then bypass (R3)
    do_reset();
    mode_i = 2'b11;
    step(); step();
    write_en(2'b10);
    det_done_i = 1; det_result_i = 3'd1;
    step();
    det_done_i = 0;
    check("R3 det end with det disabled", det_end_o, 1);
    begin
      int seen = 0;
      for (int k = 0; k < 4; k++) begin
        step();
        seen += pwr_en_o + det_start_o;
      end
      check("R3 no power without bypass", seen, 0);
    end
    det_bypass_i = 1;
    step();
    check("R3 bypass goes to class", cls_start_o, 1);
    cls_done_i = 1; cls_code_i = 3'd1;
    step();
    cls_done_i = 0;
    check("R3 bypass powers", pwr_en_o, 1);

    // midspan back-off (R11)
    do_reset();
    midspan_i = 1; tick_i = 1;
    mode_i = 2'b11;
    step(); step();
    check("R11 first detection immediate", det_start_o, 1);
    det_done_i = 1; det_result_i = 3'd2;
    step();
    det_done_i = 0;
    check("R11 det end before backoff", det_end_o, 1);
    begin
      int early = 0;
      for (int n = 1; n <= BO + 1; n++) begin
        step();
        early += det_start_o;
      end
      check("R11 no start during backoff", early, 0);
    end
    step();
    check("R11 start after backoff", det_start_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule